// File: doc/BRIEF.md
# Translated Index Bit Predictor

A cache that is indexed by physical address needs two index bits that lie above the page offset, so they only become known once address translation finishes. Rather than wait, this block guesses those two bits. The guess comes from a small history table, and the table is addressed by a slice of the register value that the address calculation starts from. The cache access then begins with the guessed bits, in parallel with the translation lookup.

In the address-add cycle the block picks one register value. It takes the base value when a base register is present and the index value when it is not. Bits [19:12] of that value address a 256-entry table of 2-bit guesses, and the entry read there is registered for the following cycle, which is the cache access cycle. In that cycle the translation logic returns the true bits. If they differ from the guess, the block flags a mispredict so that any cache hit is thrown away. It also writes the true bits into the same table entry, using the index that travelled with the request, and raises a recycle request carrying the corrected bits a fixed number of cycles later. The translation buffer, the cache arrays and the directory lie outside this block.

Top module: `xlat_bit_predictor`

## Requirements
- R1: While reset is held and right after it, pred_valid_o, mispredict_o and recycle_o are 0, and every table entry reads back as 0.
- R2: The table index is bits [19:12] of the selected register value. Bits below 12 and above 19 have no effect on the prediction.
- R3: When base_valid_i is 1 the base value selects the entry. When it is 0 the index value selects the entry and the base value is ignored.
- R4: A request accepted with req_valid_i in one cycle gives pred_valid_o = 1 and the entry contents on pred_bits_o in the next cycle. With no request, pred_valid_o is 0 in the next cycle.
- R5: mispredict_o is 1 in exactly those cycles where pred_valid_o is 1, act_valid_i is 1 and act_bits_i differs from pred_bits_o. It is 0 when the bits match.
- R6: After a mispredict, the entry at the index used for that prediction holds act_bits_i. A later request that maps to the same entry predicts those bits.
- R7: If a request reads an entry in the same cycle that a mispredict writes that entry, the request's prediction is the newly written value.
- R8: recycle_o is a one-cycle pulse that appears RECYCLE_LAT cycles after a mispredict cycle (default 2). recycle_bits_o carries the corrected bits from that mispredict.
- R9: act_valid_i with no prediction pending raises no mispredict, leaves the table unchanged and causes no recycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Address-add cycle request |
| base_valid_i | input | 1 | A base register is specified |
| base_val_i | input | XLEN | Base register value |
| index_val_i | input | XLEN | Index register value |
| act_valid_i | input | 1 | Translated bits are valid this cycle |
| act_bits_i | input | 2 | True translated index bits |
| pred_valid_o | output | 1 | Prediction valid for the cache access cycle |
| pred_bits_o | output | 2 | Predicted index bits |
| mispredict_o | output | 1 | Guess was wrong; suppress the hit |
| recycle_o | output | 1 | Re-issue the access |
| recycle_bits_o | output | 2 | Corrected bits for the re-issue |

## Verification
The stimulus pairs the same table slice with different surrounding register bits. Agreement between such pairs shows that only bits [19:12] matter. A second set of requests repeats a register value with base_valid_i switched. A base-selected entry and an index-selected entry are first trained to different values, so an answer that matches the wrong entry shows the wrong register was chosen. Each request is followed by another to the same index: a miss, then a hit, shows the table learned. A request issued in the very cycle of a mispredict to the same entry separates a write-through read from a stale one. A stray act_valid_i with nothing pending shows whether the resolve stage acts on unsolicited results.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  localparam int unsigned PRED_W = 2;
  typedef logic [PRED_W-1:0] pbits_t;

  typedef struct packed {
    logic   vld;
    pbits_t bits;
  } rcy_t;
endpackage

// File: rtl/xbp_select.sv
module xbp_select #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IDX_LSB = 12,
  parameter int unsigned IDX_W   = 8
) (
  input  logic             base_valid_i,
  input  logic [XLEN-1:0]  base_val_i,
  input  logic [XLEN-1:0]  index_val_i,
  output logic [IDX_W-1:0] tbl_idx_o
);
  localparam logic [XLEN-1:0] IDX_MASK = ((XLEN'(1) << IDX_W) - XLEN'(1)) << IDX_LSB;

  logic [XLEN-1:0] sel_val;
  logic            unused_sel;

  assign sel_val    = base_valid_i ? base_val_i : index_val_i;
  assign tbl_idx_o  = sel_val[IDX_LSB +: IDX_W];
  assign unused_sel = ^(sel_val & ~IDX_MASK);
endmodule

// File: rtl/xbp_table.sv
module xbp_table
  import xbp_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] raddr_i,
  output pbits_t           rdata_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  pbits_t           wdata_i
);
  pbits_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // write-through so a same-cycle reader sees the correction
  assign rdata_o = (we_i && (waddr_i == raddr_i)) ? wdata_i : mem_q[raddr_i];

  a_r6_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/xbp_resolve.sv
module xbp_resolve
  import xbp_pkg::*;
#(
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned RECYCLE_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  pbits_t           rd_bits_i,
  input  logic             act_valid_i,
  input  pbits_t           act_bits_i,
  output logic             pred_valid_o,
  output pbits_t           pred_bits_o,
  output logic             mispredict_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output pbits_t           wdata_o,
  output logic             recycle_o,
  output pbits_t           recycle_bits_o
);
  logic             c_vld_q;
  logic [IDX_W-1:0] c_idx_q;
  pbits_t           c_bits_q;
  rcy_t             rcy_q [RECYCLE_LAT];

  // cache access stage: prediction plus the index it came from
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_vld_q  <= 1'b0;
      c_idx_q  <= '0;
      c_bits_q <= '0;
    end else begin
      c_vld_q <= req_valid_i;
      if (req_valid_i) begin
        c_idx_q  <= req_idx_i;
        c_bits_q <= rd_bits_i;
      end
    end
  end

  assign pred_valid_o = c_vld_q;
  assign pred_bits_o  = c_bits_q;
  assign mispredict_o = c_vld_q && act_valid_i && (act_bits_i != c_bits_q);
  assign we_o         = mispredict_o;
  assign waddr_o      = c_idx_q;
  assign wdata_o      = act_bits_i;

  for (genvar s = 0; s < RECYCLE_LAT; s++) begin : g_rcy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rcy_q[s] <= '0;
      end else if (s == 0) begin
        rcy_q[s] <= '{vld: mispredict_o, bits: act_bits_i};
      end else begin
        rcy_q[s] <= rcy_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign recycle_o      = rcy_q[RECYCLE_LAT-1].vld;
  assign recycle_bits_o = rcy_q[RECYCLE_LAT-1].bits;

  // checker: every recycle must be owed by an earlier mispredict
  logic [3:0] owed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else         owed_q <= owed_q + 4'(mispredict_o) - 4'(recycle_o);
  end

  a_r8_recycle_owed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recycle_o |-> (owed_q != 4'd0));
  a_r9_no_miss_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> !mispredict_o);
endmodule

// File: rtl/xlat_bit_predictor.sv
module xlat_bit_predictor
  import xbp_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned TBL_DEPTH   = 256,
  parameter int unsigned IDX_LSB     = 12,
  parameter int unsigned RECYCLE_LAT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                base_valid_i,
  input  logic [XLEN-1:0]     base_val_i,
  input  logic [XLEN-1:0]     index_val_i,
  input  logic                act_valid_i,
  input  logic [PRED_W-1:0]   act_bits_i,
  output logic                pred_valid_o,
  output logic [PRED_W-1:0]   pred_bits_o,
  output logic                mispredict_o,
  output logic                recycle_o,
  output logic [PRED_W-1:0]   recycle_bits_o
);
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH);

  logic [IDX_W-1:0] tbl_idx;
  pbits_t           rd_bits;
  logic             we;
  logic [IDX_W-1:0] waddr;
  pbits_t           wdata;

  xbp_select #(.XLEN(XLEN), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_sel (
    .base_valid_i (base_valid_i),
    .base_val_i   (base_val_i),
    .index_val_i  (index_val_i),
    .tbl_idx_o    (tbl_idx)
  );

  xbp_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (tbl_idx),
    .rdata_o (rd_bits),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata)
  );

  xbp_resolve #(.IDX_W(IDX_W), .RECYCLE_LAT(RECYCLE_LAT)) u_res (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_idx_i      (tbl_idx),
    .rd_bits_i      (rd_bits),
    .act_valid_i    (act_valid_i),
    .act_bits_i     (act_bits_i),
    .pred_valid_o   (pred_valid_o),
    .pred_bits_o    (pred_bits_o),
    .mispredict_o   (mispredict_o),
    .we_o           (we),
    .waddr_o        (waddr),
    .wdata_o        (wdata),
    .recycle_o      (recycle_o),
    .recycle_bits_o (recycle_bits_o)
  );

  a_r4_pred_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o == $past(req_valid_i));
  a_r5_miss_needs_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> (act_valid_i && pred_valid_o));
endmodule

// File: tb/tb_xlat_bit_predictor.sv
`timescale 1ns/1ps
module tb_xlat_bit_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        base_valid_i = 1'b0;
  logic [31:0] base_val_i = '0;
  logic [31:0] index_val_i = '0;
  logic        act_valid_i = 1'b0;
  logic [1:0]  act_bits_i = '0;
  logic        pred_valid_o;
  logic [1:0]  pred_bits_o;
  logic        mispredict_o;
  logic        recycle_o;
  logic [1:0]  recycle_bits_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  xlat_bit_predictor dut (
    .clk_i, .rst_ni, .req_valid_i, .base_valid_i, .base_val_i, .index_val_i,
    .act_valid_i, .act_bits_i, .pred_valid_o, .pred_bits_o, .mispredict_o,
    .recycle_o, .recycle_bits_o
  );

  // {base_valid, base, index, actual, expected prediction, expected mispredict}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 32'h0000_5000, 32'h0000_0000, 2'd2, 2'd0, 1'b1}, // R6 train 0x05
    {1'b1, 32'h1230_5abc, 32'h0000_0000, 2'd2, 2'd2, 1'b0}, // R2 same slice
    {1'b0, 32'h0000_5000, 32'h0007_7000, 2'd1, 2'd0, 1'b1}, // R3 index used
    {1'b0, 32'hdead_5000, 32'h0ff7_7fff, 2'd1, 2'd1, 1'b0}, // R3 base ignored
    {1'b1, 32'hffff_f000, 32'h0007_7000, 2'd3, 2'd0, 1'b1}, // R3 base wins
    {1'b1, 32'h000f_f000, 32'h0000_0000, 2'd0, 2'd3, 1'b1}, // R6 retrain
    {1'b1, 32'h000f_f123, 32'h0000_0000, 2'd0, 2'd0, 1'b0},
    {1'b1, 32'h0000_0fff, 32'h0000_0000, 2'd0, 2'd0, 1'b0}, // R2 low bits
    {1'b1, 32'h0010_0000, 32'h0000_0000, 2'd3, 2'd0, 1'b1}, // R2 high bits
    {1'b1, 32'h0000_0000, 32'h0000_0000, 2'd3, 2'd3, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one request through both stages plus the recycle window
  task automatic run_req(input logic bv, input logic [31:0] b, input logic [31:0] x,
                         input logic [1:0] act, input logic [1:0] ep, input logic em);
    @(negedge clk_i);
    req_valid_i = 1'b1; base_valid_i = bv; base_val_i = b; index_val_i = x;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R4 pred_valid", 32'(pred_valid_o), 1);
    chk("R2/R3/R6 pred_bits", 32'(pred_bits_o), 32'(ep));
    act_valid_i = 1'b1; act_bits_i = act;
    #1;
    chk("R5 mispredict", 32'(mispredict_o), 32'(em));
    @(negedge clk_i);
    act_valid_i = 1'b0;
    chk("R4 pred_valid idle", 32'(pred_valid_o), 0);
    chk("R8 recycle early", 32'(recycle_o), 0);
    @(negedge clk_i);
    chk("R8 recycle", 32'(recycle_o), 32'(em));
    if (em) chk("R8 recycle_bits", 32'(recycle_bits_o), 32'(act));
    @(negedge clk_i);
    chk("R8 recycle pulse end", 32'(recycle_o), 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL all: watchdog at cycle %0d expected under 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1 pred_valid", 32'(pred_valid_o), 0);
    chk("R1 mispredict", 32'(mispredict_o), 0);
    chk("R1 recycle", 32'(recycle_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      run_req(v[69], v[68:37], v[36:5], v[4:3], v[2:1], v[0]);
    end

    // R7 same-cycle write and read of entry 0x30
    @(negedge clk_i);
    req_valid_i = 1'b1; base_valid_i = 1'b1; base_val_i = 32'h0003_0000;
    @(negedge clk_i);
    chk("R7 first pred", 32'(pred_bits_o), 0);
    act_valid_i = 1'b1; act_bits_i = 2'd2;
    #1;
    chk("R7 mispredict", 32'(mispredict_o), 1);
    @(negedge clk_i);
    req_valid_i = 1'b0; act_valid_i = 1'b0;
    chk("R7 pred_valid", 32'(pred_valid_o), 1);
    chk("R7 bypass pred", 32'(pred_bits_o), 2);
    chk("R8 recycle early", 32'(recycle_o), 0);
    @(negedge clk_i);
    chk("R8 recycle", 32'(recycle_o), 1);
    chk("R8 recycle_bits", 32'(recycle_bits_o), 2);
    @(negedge clk_i);
    chk("R8 pulse end", 32'(recycle_o), 0);

    // R9 stray result with nothing pending
    act_valid_i = 1'b1; act_bits_i = 2'd1;
    #1;
    chk("R9 no mispredict", 32'(mispredict_o), 0);
    @(negedge clk_i); act_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R9 no recycle", 32'(recycle_o), 0);
    run_req(1'b1, 32'h0003_0000, 32'h0, 2'd2, 2'd2, 1'b0); // R9 entry kept

    // R1 reset clears trained entries
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R1 pred_valid in reset", 32'(pred_valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_req(1'b1, 32'h0000_5000, 32'h0, 2'd0, 2'd0, 1'b0); // R1 entry 0x05 zero
    run_req(1'b1, 32'h0003_0000, 32'h0, 2'd0, 2'd0, 1'b0); // R1 entry 0x30 zero

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule